// File: doc/BRIEF.md
# 16-Point Radix-2 FFT Engine

This block computes a 16-point discrete Fourier transform of real 12-bit signed samples. It uses one shared butterfly unit and a small register file that is updated in place. A frame of sixteen samples streams in over a valid/ready port. Each sample goes into the register file at the bit-reversed position of its arrival index. A one-cycle `start` pulse then launches four decimation-in-time stages of eight butterflies each, one butterfly per clock.

After the last butterfly the engine pulses `done` and streams the sixteen complex bins out in natural order over a second valid/ready port. Each bin is tagged with its index. When the last bin has been accepted, the engine is ready for the next frame.

Each butterfly forms a + W·b and a − W·b with a single complex product, since the twiddle of the lower half is the negation of the upper one. Every stage halves its results, so the output is the transform scaled by 1/16. Both stream ports follow the same rules:
- A transfer happens on a clock edge where valid and ready are both high.
- While an output is offered and not taken, its index and data hold still.
- The engine never offers a bin while it is accepting samples.

Top module: `fft16_engine`

## Requirements
- R1: After reset and after each completed output stream, `in_ready` is high. Exactly sixteen samples are taken, one on each edge with `in_valid` high. `in_ready` falls in the cycle after the sixteenth sample is taken. Sample n (n = 0..15, arrival order) is placed at the position whose 4-bit index is n bit-reversed.
- R2: `start` has an effect only when sixteen samples are loaded and no transform is running. During load, computation or output streaming it is ignored, and exactly one `done` occurs per frame.
- R3: `done` is high for exactly one cycle, 32 cycles after the edge that samples `start` in the loaded state.
- R4: The results are bit-exact to the following fixed-point rules.
  - Data are 16-bit two's complement. Each input sample is sign-extended into the real part, and the imaginary part is 0.
  - Twiddle k (k = 0..7) is cos(2πk/16) and −sin(2πk/16) in Q1.14, rounded to nearest.
  - The product W·b is computed as one sum per component, adds 2^13, and is arithmetically shifted right by 14.
  - Each butterfly output is (a ± W·b) arithmetically shifted right by 1.
- R5: Stage s (s = 0..3) pairs points 2^s apart. Within a pair group, the twiddle index advances by 8/2^s per position. Within one butterfly cycle, the two written positions always differ.
- R6: Starting in the cycle of `done`, `out_valid` is high and bins 0..15 are presented in natural order, with `out_idx` equal to the bin number. The index advances only on an edge with `out_valid` and `out_ready` both high. While stalled, `out_idx`, `out_re` and `out_im` stay stable.
- R7: In the cycle after bin 15 is accepted, `out_valid` is low and `in_ready` is high.
- R8: Bins 0 and 8 have an imaginary part of exactly 0. For k = 1..7, bin k matches the conjugate of bin 16−k to within 4 LSB in each component.
- R9: `in_ready` and `out_valid` are never high together. `in_valid` outside the load phase has no effect on the results.
- R10: While reset is held, `in_ready` is 1 and `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine accepts a sample |
| in_data | input | 12 | Signed real sample |
| start | input | 1 | Launch the transform of the loaded frame |
| done | output | 1 | One-cycle pulse after the last butterfly |
| out_valid | output | 1 | Bin offered |
| out_ready | input | 1 | Consumer takes the bin |
| out_idx | output | 4 | Bin number of the offered bin |
| out_re | output | 16 | Real part of the bin, two's complement |
| out_im | output | 16 | Imaginary part of the bin, two's complement |

## Verification
The bench runs a behavioural reference model in lock-step with the design and compares all outputs at the falling edge of every clock. Its latencies are as follows:
- `in_ready` drops one cycle after the sixteenth accepted sample.
- `done` and bin 0 appear exactly 32 cycles after the start edge.
- Each new bin appears one cycle after a handshake.
- `in_ready` returns one cycle after bin 15 is taken.

The bench varies the stimulus across frames. It inserts gaps in the input, stalls the output at random, and drives `start` and `in_valid` in phases where they must be ignored. Every data comparison uses the fixed-point transform computed independently in the bench.

// File: rtl/fft16_pkg.sv
package fft16_pkg;
  localparam int NPT   = 16;
  localparam int LOGN  = $clog2(NPT);
  localparam int AW    = LOGN;
  localparam int DW    = 12;
  localparam int IW    = DW + 4;
  localparam int TW    = 16;
  localparam int TFRAC = 14;
  localparam int NHALF = NPT / 2;

  typedef struct packed {
    logic signed [IW-1:0] re;
    logic signed [IW-1:0] im;
  } cplx_t;

  typedef enum logic [1:0] {ST_LOAD, ST_ARMED, ST_RUN, ST_OUT} eng_state_t;

  function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = a[AW-1-i];
    return r;
  endfunction
endpackage

// File: rtl/fft16_twiddle.sv
module fft16_twiddle #(
  parameter int TWW = fft16_pkg::TW,
  parameter int KW  = fft16_pkg::LOGN - 1
) (
  input  logic [KW-1:0]         k,
  output logic signed [TWW-1:0] w_re,
  output logic signed [TWW-1:0] w_im
);
  localparam int NK = 2 ** KW;
  // Q1.14 cosine and negated sine for the 16-point circle
  localparam logic signed [TWW-1:0] COS_T [NK] = '{
    TWW'(16384), TWW'(15137), TWW'(11585), TWW'(6270),
    TWW'(0), TWW'(-6270), TWW'(-11585), TWW'(-15137)};
  localparam logic signed [TWW-1:0] NSIN_T [NK] = '{
    TWW'(0), TWW'(-6270), TWW'(-11585), TWW'(-15137),
    TWW'(-16384), TWW'(-15137), TWW'(-11585), TWW'(-6270)};

  assign w_re = COS_T[k];
  assign w_im = NSIN_T[k];
endmodule

// File: rtl/fft16_bfly.sv
module fft16_bfly
  import fft16_pkg::*;
#(
  parameter int DIW  = fft16_pkg::IW,
  parameter int DTW  = fft16_pkg::TW,
  parameter int FRAC = fft16_pkg::TFRAC
) (
  input  cplx_t                 a,
  input  cplx_t                 b,
  input  logic signed [DTW-1:0] w_re,
  input  logic signed [DTW-1:0] w_im,
  output cplx_t                 x,
  output cplx_t                 y
);
  localparam int PW = DIW + DTW + 1;
  localparam int SW = DIW + 2;
  localparam logic signed [PW-1:0] RND = PW'(2 ** (FRAC - 1));

  logic signed [PW-1:0] p_re, p_im, t_re, t_im;
  logic signed [SW-1:0] sx_re, sx_im, sy_re, sy_im;

  // single complex product, shared by the sum and the difference
  always_comb begin
    p_re  = PW'(b.re) * PW'(w_re) - PW'(b.im) * PW'(w_im) + RND;
    p_im  = PW'(b.re) * PW'(w_im) + PW'(b.im) * PW'(w_re) + RND;
    t_re  = p_re >>> FRAC;
    t_im  = p_im >>> FRAC;
    sx_re = SW'(a.re) + SW'(t_re);
    sx_im = SW'(a.im) + SW'(t_im);
    sy_re = SW'(a.re) - SW'(t_re);
    sy_im = SW'(a.im) - SW'(t_im);
    x.re  = DIW'(sx_re >>> 1);
    x.im  = DIW'(sx_im >>> 1);
    y.re  = DIW'(sy_re >>> 1);
    y.im  = DIW'(sy_im >>> 1);
  end
endmodule

// File: rtl/fft16_agen.sv
module fft16_agen #(
  parameter int LG = fft16_pkg::LOGN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [LG-1:0] top,
  output logic [LG-1:0] bot,
  output logic [LG-2:0] tw_k,
  output logic          last
);
  localparam int SW = $clog2(LG);
  localparam int KW = LG - 1;

  logic [SW-1:0] stg;
  logic [KW-1:0] bf;
  logic [LG-1:0] bfx, span, msk, pos;
  logic [SW-1:0] shamt;

  always_comb begin
    bfx   = LG'(bf);
    span  = LG'(1) << stg;
    msk   = span - LG'(1);
    pos   = bfx & msk;
    top   = (((bfx >> stg) << stg) << 1) | pos;
    bot   = top | span;
    shamt = SW'(KW) - stg;
    tw_k  = KW'(pos << shamt);
    last  = (stg == SW'(LG - 1)) && (bf == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
      bf  <= '0;
    end else if (en) begin
      if (bf == '1) begin
        bf  <= '0;
        stg <= last ? '0 : stg + 1'b1;
      end else begin
        bf <= bf + 1'b1;
      end
    end
  end

  assert_wrap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |=> (stg == '0 && bf == '0));
endmodule

// File: rtl/fft16_mem.sv
module fft16_mem
  import fft16_pkg::*;
#(
  parameter int DEPTH = fft16_pkg::NPT,
  parameter int MAW   = fft16_pkg::AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we0,
  input  logic [MAW-1:0] wa0,
  input  cplx_t          wd0,
  input  logic           we1,
  input  logic [MAW-1:0] wa1,
  input  cplx_t          wd1,
  input  logic [MAW-1:0] ra0,
  output cplx_t          rd0,
  input  logic [MAW-1:0] ra1,
  output cplx_t          rd1
);
  cplx_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we0 && wa0 == MAW'(i))      mem[i] <= wd0;
        else if (we1 && wa1 == MAW'(i)) mem[i] <= wd1;
      end
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];

  assert_distinct_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && we1) |-> (wa0 != wa1));
endmodule

// File: rtl/fft16_engine.sv
module fft16_engine
  import fft16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          start,
  output logic          done,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_idx,
  output logic [IW-1:0] out_re,
  output logic [IW-1:0] out_im
);
  eng_state_t state;
  logic [AW-1:0] cnt;
  logic          done_q;

  logic            run_en, take_in, take_out;
  logic [AW-1:0]   bf_top, bf_bot;
  logic [AW-2:0]   tw_k;
  logic            bf_last;
  logic signed [TW-1:0] w_re, w_im;
  cplx_t           rd0, rd1, bx, by, load_word, wd0;
  logic [AW-1:0]   wa0, ra0;
  logic            we0;

  assign run_en   = (state == ST_RUN);
  assign take_in  = (state == ST_LOAD) && in_valid;
  assign take_out = (state == ST_OUT) && out_ready;

  always_comb begin
    load_word.re = {{(IW - DW){in_data[DW-1]}}, in_data};
    load_word.im = '0;
    we0 = take_in || run_en;
    wa0 = run_en ? bf_top : bitrev(cnt);
    wd0 = run_en ? bx : load_word;
    ra0 = run_en ? bf_top : cnt;
  end

  fft16_agen #(.LG(LOGN)) u_agen (
    .clk(clk), .rst_n(rst_n), .en(run_en),
    .top(bf_top), .bot(bf_bot), .tw_k(tw_k), .last(bf_last));

  fft16_twiddle #(.TWW(TW), .KW(LOGN - 1)) u_tw (
    .k(tw_k), .w_re(w_re), .w_im(w_im));

  fft16_mem #(.DEPTH(NPT), .MAW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we0(we0), .wa0(wa0), .wd0(wd0),
    .we1(run_en), .wa1(bf_bot), .wd1(by),
    .ra0(ra0), .rd0(rd0), .ra1(bf_bot), .rd1(rd1));

  fft16_bfly #(.DIW(IW), .DTW(TW), .FRAC(TFRAC)) u_bfly (
    .a(rd0), .b(rd1), .w_re(w_re), .w_im(w_im), .x(bx), .y(by));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_LOAD: if (take_in) begin
          cnt <= cnt + 1'b1;
          if (cnt == '1) state <= ST_ARMED;
        end
        ST_ARMED: if (start) state <= ST_RUN;
        ST_RUN: if (bf_last) begin
          state  <= ST_OUT;
          done_q <= 1'b1;
        end
        ST_OUT: if (take_out) begin
          cnt <= cnt + 1'b1;
          if (cnt == '1) state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_OUT);
  assign out_idx   = cnt;
  assign out_re    = rd0.re;
  assign out_im    = rd0.im;
  assign done      = done_q;

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == ST_RUN));
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_re) && $stable(out_im)));
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_idx != '1) |=> (out_idx == $past(out_idx) + 1'b1));
  assert_ready_after_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_idx == '1) |=> (in_ready && !out_valid));
endmodule

// File: tb/fft16_engine_tb.sv
module fft16_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic [11:0] in_data = '0;
  logic in_ready, done, out_valid;
  logic [3:0] out_idx;
  logic [15:0] out_re, out_im;

  int checks = 0, errors = 0;
  int twr[8], twi[8];
  int fr[16], smp[16], er[16], ei[16], gr[16], gi[16];
  int mphase = 0, mcnt = 0, mrun = 0, frames = 0, done_seen = 0;
  bit mdone = 0;

  always #5 clk = ~clk;

  fft16_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .start(start), .done(done), .out_valid(out_valid),
    .out_ready(out_ready), .out_idx(out_idx), .out_re(out_re), .out_im(out_im));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rev4(input int v);
    int r = 0;
    for (int i = 0; i < 4; i++) if (v & (1 << i)) r |= (1 << (3 - i));
    return r;
  endfunction

  // fixed-point reference transform, classic nested-size formulation
  task automatic compute_ref();
    longint ar[16], ai[16];
    for (int n = 0; n < 16; n++) begin
      ar[rev4(n)] = smp[n];
      ai[rev4(n)] = 0;
    end
    for (int m = 2; m <= 16; m = m * 2) begin
      for (int k0 = 0; k0 < 16; k0 += m) begin
        for (int j = 0; j < m / 2; j++) begin
          int t = k0 + j;
          int b = t + m / 2;
          int w = j * (16 / m);
          longint pr = (ar[b] * twr[w] - ai[b] * twi[w] + 8192) >>> 14;
          longint pi = (ar[b] * twi[w] + ai[b] * twr[w] + 8192) >>> 14;
          longint tr = ar[t], ti = ai[t];
          ar[t] = (tr + pr) >>> 1;
          ai[t] = (ti + pi) >>> 1;
          ar[b] = (tr - pr) >>> 1;
          ai[b] = (ti - pi) >>> 1;
        end
      end
    end
    for (int n = 0; n < 16; n++) begin
      er[n] = int'(ar[n]);
      ei[n] = int'(ai[n]);
    end
  endtask

  // lock-step model of the handshakes and timing
  always @(posedge clk) begin
    if (!rst_n) begin
      mphase = 0; mcnt = 0; mrun = 0; mdone = 0;
    end else begin
      mdone = 0;
      if (done) done_seen++;
      case (mphase)
        0: if (in_valid) begin
          smp[mcnt] = int'($signed(in_data));
          if (mcnt == 15) begin mphase = 1; mcnt = 0; end
          else mcnt++;
        end
        1: if (start) begin compute_ref(); mphase = 2; mrun = 0; end
        2: begin
          mrun++;
          if (mrun == 32) begin mphase = 3; mdone = 1; mcnt = 0; end
        end
        default: if (out_ready) begin
          gr[mcnt] = int'($signed(out_re));
          gi[mcnt] = int'($signed(out_im));
          if (mcnt == 15) begin mphase = 0; mcnt = 0; end
          else mcnt++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    check(in_ready == (mphase == 0), "R1/R7/R9 in_ready", in_ready, mphase == 0);
    check(out_valid == (mphase == 3), "R6/R9 out_valid", out_valid, mphase == 3);
    check(done == mdone, "R3 done", done, mdone);
    if (mphase == 3 && out_valid) begin
      check(out_idx == 4'(mcnt), "R6 out_idx", out_idx, mcnt);
      // R4 R5: bit-exact bins
      check(int'($signed(out_re)) == er[mcnt], "R4 out_re", $signed(out_re), er[mcnt]);
      check(int'($signed(out_im)) == ei[mcnt], "R4 out_im", $signed(out_im), ei[mcnt]);
    end
  end

  task automatic fill(input int kind);
    for (int n = 0; n < 16; n++) begin
      case (kind)
        0: fr[n] = (n == 0) ? 2047 : 0;
        1: fr[n] = -2048;
        2: fr[n] = (n % 2 == 0) ? 2047 : -2048;
        3: fr[n] = int'(1500.0 * $cos(2.0 * 3.14159265358979 * 3.0 * n / 16.0));
        4: fr[n] = int'($urandom % 4096) - 2048;
        default: fr[n] = n * 250 - 1900;
      endcase
    end
  endtask

  task automatic run_frame(input int kind, input bit gaps, input bit stalls);
    fill(kind);
    for (int n = 0; n < 16; n++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0; start = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = 12'(fr[n]);
      start    = (n == 5);            // R2: ignored while loading
      @(negedge clk);
    end
    in_valid = 1'b1; in_data = 12'h5A5; start = 1'b0;  // R9: ignored when armed
    repeat (2) @(negedge clk);
    in_valid = 1'b0; start = 1'b1;
    @(negedge clk);
    while (1) begin
      @(negedge clk);
      if (mphase == 0) break;
      in_valid  = 1'b1;               // R9: ignored during run and output
      in_data   = 12'($urandom);
      start     = ($urandom % 4 == 0); // R2: ignored during run and output
      out_ready = stalls ? 1'($urandom % 2) : 1'b1;
    end
    in_valid = 1'b0; start = 1'b0; out_ready = 1'b1;
    frames++;
    check(done_seen == frames, "R2 one done per frame", done_seen, frames);
    // R8: real-input symmetry of the collected bins
    check(gi[0] == 0, "R8 bin0 imag", gi[0], 0);
    check(gi[8] == 0, "R8 bin8 imag", gi[8], 0);
    for (int k = 1; k < 8; k++) begin
      int dr = gr[k] - gr[16 - k];
      int di = gi[k] + gi[16 - k];
      check(dr <= 4 && dr >= -4, "R8 conj real", gr[k], gr[16 - k]);
      check(di <= 4 && di >= -4, "R8 conj imag", gi[k], -gi[16 - k]);
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      twr[k] = int'(16384.0 * $cos(2.0 * 3.14159265358979 * k / 16.0));
      twi[k] = -int'(16384.0 * $sin(2.0 * 3.14159265358979 * k / 16.0));
    end
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R10 reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    check(done == 1'b0, "R10 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 1'b0, 1'b0);
    run_frame(1, 1'b1, 1'b0);
    run_frame(2, 1'b0, 1'b1);
    run_frame(3, 1'b1, 1'b1);
    run_frame(4, 1'b1, 1'b1);
    run_frame(5, 1'b0, 1'b1);
    run_frame(4, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule